// File: doc/BRIEF.md
# Multi-Port Hardware Lock Bank

This block holds a bank of hardware locks that several requesters share, so that software on different processors can claim a shared resource and hand it back. Each lock has a lock flag and the 8-bit CPU ID of its owner. When protection is enabled, it also records a hidden hardware ID, made of the port number and the source tag of the master that claimed it. Beside each lock there can be a 32-bit user word, which is plain storage with no ownership check.

Every requester drives its own request port: a valid/ready handshake carrying write-enable, word address, 32-bit write data and a source tag. Only one port is served per cycle, and a fixed priority picks it, with port 0 highest. A request is accepted in the cycle where both valid and ready are high. A port that loses must hold valid and all of its fields stable until ready rises. There is no back-pressure on the response side. One cycle after acceptance the port's done bit pulses for one cycle, and the shared read-data bus carries the result.

Software claims a lock by writing lock flag 1 with its ID. It then reads the lock word back to confirm that the stored ID is its own, and retries if it is not. It releases the lock by writing lock flag 0 with the same ID.

Top module: `hwlock_bank`

## Requirements
- R1: After reset every lock word and every user word reads zero.
- R2: A write to lock offset 0 with bit 0 = 1 on a free lock sets it: the lock word then reads {23'b0, cpu_id[7:0], 1'b1}, with the CPU ID taken from write-data bits [8:1].
- R3: A claim write to a lock that is already held leaves its word unchanged.
- R4: A write with bit 0 = 0 clears the whole lock word to zero when bits [8:1] equal the stored owner ID and the accessing port and source tag equal those of the claimer.
- R5: A release that carries a CPU ID different from the stored owner leaves the lock unchanged.
- R6: With protection enabled, a release that carries the correct CPU ID but comes from another port, or from another source tag on the same port, leaves the lock unchanged.
- R7: Word offset 1 of each lock is a 32-bit user word. Any port may read or write it whether or not the lock is held. With the user word disabled it reads zero.
- R8: Word offsets 2 to 63 read zero and ignore writes. A lock index (address bits [10:6]) at or above the configured count reads zero and ignores writes, and such writes alter no other lock.
- R9: When several ports are valid, ready goes to the lowest-numbered valid port only. The other ports wait, and are served in later cycles.
- R10: The port's done bit pulses for exactly one cycle, in the cycle after its handshake. At that time resp_rdata holds the addressed word for a read and zero for a write.
- R11: Write-data bits [31:9] and the hidden hardware ID never appear in lock read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Per-port request valid |
| req_ready | output | NUM_PORTS | Per-port grant; handshake when valid and ready |
| req_we | input | NUM_PORTS | Per-port write enable |
| req_addr | input | NUM_PORTS x 11 | Per-port word address: [10:6] lock index, [5:0] word offset |
| req_wdata | input | NUM_PORTS x 32 | Per-port write data |
| req_src | input | NUM_PORTS x SRC_W | Per-port master/source tag, part of the hidden hardware ID |
| resp_done | output | NUM_PORTS | One-cycle completion pulse per port |
| resp_rdata | output | 32 | Read data of the completing access |

## Verification
The bench builds the bank with three ports, five locks, a 2-bit source tag, and both protection and the user word enabled. Five locks leave indices 5 to 31 addressable but unbuilt, so the out-of-range path is exercised. Three ports make the middle port a loser in the priority case. Two source tags on one port let a release with the right CPU ID be refused purely on the hidden hardware ID.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
  localparam int CPU_ID_W = 8;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 5;
  localparam int OFF_W    = 6;
  localparam int ADDR_W   = IDX_W + OFF_W;

  typedef enum logic [1:0] {
    SLOT_LOCK = 2'd0,
    SLOT_USER = 2'd1,
    SLOT_RSVD = 2'd2
  } slot_e;

  function automatic slot_e decode_slot(input logic [OFF_W-1:0] off);
    if (off == OFF_W'(0))      return SLOT_LOCK;
    else if (off == OFF_W'(1)) return SLOT_USER;
    else                       return SLOT_RSVD;
  endfunction
endpackage

// File: rtl/hwlock_arb.sv
module hwlock_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] valid,
  output logic [N-1:0] grant
);
  logic taken;
  always_comb begin
    taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      grant[i] = valid[i] & ~taken;
      taken    = taken | valid[i];
    end
  end
endmodule

// File: rtl/hwlock_cell.sv
module hwlock_cell
  import hwlock_pkg::*;
#(
  parameter int HW_W       = 4,
  parameter bit HW_PROTECT = 1'b1,
  parameter bit USER_WORD  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              we,
  input  slot_e             slot,
  input  logic [WORD_W-1:0] wdata,
  input  logic [HW_W-1:0]   hwid,
  output logic [WORD_W-1:0] lock_word,
  output logic [WORD_W-1:0] user_word
);
  logic                locked_q;
  logic [CPU_ID_W-1:0] owner_q;
  logic [CPU_ID_W-1:0] id_w;
  logic                hw_ok;
  logic                lock_wr, claim, release_ok;

  assign id_w       = wdata[CPU_ID_W:1];
  assign lock_wr    = hit & we & (slot == SLOT_LOCK);
  assign claim      = lock_wr & wdata[0] & ~locked_q;
  assign release_ok = lock_wr & ~wdata[0] & locked_q & (owner_q == id_w) & hw_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
    end else if (claim) begin
      locked_q <= 1'b1;
      owner_q  <= id_w;
    end else if (release_ok) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
    end
  end

  generate
    if (HW_PROTECT) begin : g_hw
      logic [HW_W-1:0] hw_q;
      always_ff @(posedge clk) begin
        if (!rst_n)          hw_q <= '0;
        else if (claim)      hw_q <= hwid;
        else if (release_ok) hw_q <= '0;
      end
      assign hw_ok = (hw_q == hwid);
    end else begin : g_nohw
      assign hw_ok = 1'b1;
    end

    if (USER_WORD) begin : g_user
      logic [WORD_W-1:0] user_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                            user_q <= '0;
        else if (hit && we && slot == SLOT_USER) user_q <= wdata;
      end
      assign user_word = user_q;
    end else begin : g_nouser
      assign user_word = '0;
    end
  endgenerate

  assign lock_word = {{(WORD_W-CPU_ID_W-1){1'b0}}, owner_q, locked_q};
endmodule

// File: rtl/hwlock_bank.sv
module hwlock_bank
  import hwlock_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_LOCKS  = 16,
  parameter int SRC_W      = 4,
  parameter bit HW_PROTECT = 1'b1,
  parameter bit USER_WORD  = 1'b1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_PORTS-1:0]                req_valid,
  output logic [NUM_PORTS-1:0]                req_ready,
  input  logic [NUM_PORTS-1:0]                req_we,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    req_addr,
  input  logic [NUM_PORTS-1:0][WORD_W-1:0]    req_wdata,
  input  logic [NUM_PORTS-1:0][SRC_W-1:0]     req_src,
  output logic [NUM_PORTS-1:0]                resp_done,
  output logic [WORD_W-1:0]                   resp_rdata
);
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int HW_W   = PORT_W + SRC_W;

  logic [NUM_PORTS-1:0] grant;
  logic                 any_grant;
  logic                 sel_we;
  logic [ADDR_W-1:0]    sel_addr;
  logic [WORD_W-1:0]    sel_wdata;
  logic [SRC_W-1:0]     sel_src;
  logic [PORT_W-1:0]    sel_port;
  logic [IDX_W-1:0]     idx;
  slot_e                slot;
  logic                 in_range;
  logic [HW_W-1:0]      hwid;
  logic [WORD_W-1:0]    rd_val;
  logic [NUM_LOCKS-1:0][WORD_W-1:0] lock_words, user_words;
  logic [NUM_PORTS-1:0] done_q;
  logic [WORD_W-1:0]    rdata_q;

  hwlock_arb #(.N(NUM_PORTS)) u_arb (.valid(req_valid), .grant(grant));

  assign req_ready = grant;
  assign any_grant = |grant;

  always_comb begin
    sel_we    = 1'b0;
    sel_addr  = '0;
    sel_wdata = '0;
    sel_src   = '0;
    sel_port  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (grant[p]) begin
        sel_we    = req_we[p];
        sel_addr  = req_addr[p];
        sel_wdata = req_wdata[p];
        sel_src   = req_src[p];
        sel_port  = PORT_W'(p);
      end
    end
  end

  assign idx      = sel_addr[ADDR_W-1:OFF_W];
  assign slot     = decode_slot(sel_addr[OFF_W-1:0]);
  assign in_range = (int'(idx) < NUM_LOCKS);
  assign hwid     = {sel_port, sel_src};

  generate
    for (genvar k = 0; k < NUM_LOCKS; k++) begin : g_cell
      hwlock_cell #(
        .HW_W(HW_W), .HW_PROTECT(HW_PROTECT), .USER_WORD(USER_WORD)
      ) u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (any_grant && in_range && (idx == IDX_W'(k))),
        .we        (sel_we),
        .slot      (slot),
        .wdata     (sel_wdata),
        .hwid      (hwid),
        .lock_word (lock_words[k]),
        .user_word (user_words[k])
      );
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NUM_LOCKS; k++) begin
      if (idx == IDX_W'(k)) begin
        if (slot == SLOT_LOCK)      rd_val = lock_words[k];
        else if (slot == SLOT_USER) rd_val = user_words[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= '0;
      rdata_q <= '0;
    end else begin
      done_q  <= grant;
      rdata_q <= (any_grant && !sel_we) ? rd_val : '0;
    end
  end

  assign resp_done  = done_q;
  assign resp_rdata = rdata_q;
endmodule

// File: rtl/hwlock_bank_chk.sv
module hwlock_bank_chk #(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] req_valid,
  input logic [NUM_PORTS-1:0] req_ready,
  input logic [NUM_PORTS-1:0] resp_done
);
  // R9
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  // R9
  grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  // R9
  grant_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready != '0) |-> ((req_valid & (req_ready - 1'b1)) == '0));

  // R10
  done_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready != '0) |=> (resp_done == $past(req_ready)));

  // R10
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready == '0) |=> (resp_done == '0));
endmodule

bind hwlock_bank hwlock_bank_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .resp_done (resp_done)
);

// File: tb/hwlock_bank_bench.sv
module hwlock_bank_bench;
  import hwlock_pkg::*;
  localparam int NP = 3;
  localparam int NL = 5;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]             req_valid = '0;
  logic [NP-1:0]             req_ready;
  logic [NP-1:0]             req_we = '0;
  logic [NP-1:0][ADDR_W-1:0] req_addr = '0;
  logic [NP-1:0][WORD_W-1:0] req_wdata = '0;
  logic [NP-1:0][SW-1:0]     req_src = '0;
  logic [NP-1:0]             resp_done;
  logic [WORD_W-1:0]         resp_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hwlock_bank #(
    .NUM_PORTS(NP), .NUM_LOCKS(NL), .SRC_W(SW), .HW_PROTECT(1'b1), .USER_WORD(1'b1)
  ) u_hwlock_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_src(req_src),
    .resp_done(resp_done), .resp_rdata(resp_rdata)
  );

  function automatic logic [ADDR_W-1:0] la(input int k, input int off);
    return ADDR_W'((k << OFF_W) | off);
  endfunction

  function automatic logic [31:0] lw(input logic [7:0] id, input logic f);
    return {23'b0, id, f};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input int p, input logic we, input logic [ADDR_W-1:0] a,
                        input logic [31:0] wd, input logic [SW-1:0] src,
                        output logic [31:0] rd);
    logic g;
    @(negedge clk);
    req_we[p] = we; req_addr[p] = a; req_wdata[p] = wd; req_src[p] = src;
    req_valid[p] = 1'b1;
    forever begin
      #1;
      g = req_ready[p];
      @(posedge clk);
      if (g) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid[p] = 1'b0;
    chk("R10 done", 32'(resp_done), 32'(1 << p));
    rd = resp_rdata;
  endtask

  task automatic rd_chk(input string req, input int p, input logic [ADDR_W-1:0] a,
                        input logic [31:0] exp);
    logic [31:0] r;
    access(p, 1'b0, a, 32'h0, '0, r);
    chk(req, r, exp);
  endtask

  task automatic wr(input int p, input logic [ADDR_W-1:0] a, input logic [31:0] wd,
                    input logic [SW-1:0] src);
    logic [31:0] r;
    access(p, 1'b1, a, wd, src, r);
    chk("R10 write rdata zero", r, 32'h0);
  endtask

  task automatic t_reset();
    for (int k = 0; k < NL; k++) begin
      rd_chk("R1 lock reset", 0, la(k, 0), 32'h0);
      rd_chk("R1 user reset", 1, la(k, 1), 32'h0);
    end
  endtask

  task automatic t_claim();
    wr(0, la(2, 0), lw(8'h5A, 1'b1), 2'd1);
    rd_chk("R2 claim", 1, la(2, 0), 32'h0000_00B5);
    wr(1, la(2, 0), lw(8'h33, 1'b1), 2'd0);
    rd_chk("R3 claim held ignored", 2, la(2, 0), 32'h0000_00B5);
    wr(2, la(3, 0), 32'hFFFF_FE00 | lw(8'h5A, 1'b1), 2'd3);
    rd_chk("R11 upper bits dropped", 0, la(3, 0), 32'h0000_00B5);
  endtask

  task automatic t_release();
    wr(0, la(2, 0), lw(8'h33, 1'b0), 2'd1);
    rd_chk("R5 wrong id release", 0, la(2, 0), 32'h0000_00B5);
    wr(1, la(2, 0), lw(8'h5A, 1'b0), 2'd1);
    rd_chk("R6 other port release", 0, la(2, 0), 32'h0000_00B5);
    wr(0, la(2, 0), lw(8'h5A, 1'b0), 2'd2);
    rd_chk("R6 other src release", 0, la(2, 0), 32'h0000_00B5);
    wr(0, la(2, 0), lw(8'h5A, 1'b0), 2'd1);
    rd_chk("R4 owner release", 1, la(2, 0), 32'h0);
    wr(2, la(3, 0), lw(8'h5A, 1'b0), 2'd3);
    rd_chk("R4 owner release 2", 2, la(3, 0), 32'h0);
  endtask

  task automatic t_user();
    wr(2, la(4, 1), 32'hDEAD_BEEF, 2'd0);
    rd_chk("R7 user rw", 1, la(4, 1), 32'hDEAD_BEEF);
    wr(1, la(4, 0), lw(8'h11, 1'b1), 2'd0);
    wr(2, la(4, 1), 32'h1234_5678, 2'd0);
    rd_chk("R7 user while held", 0, la(4, 1), 32'h1234_5678);
    rd_chk("R7 lock kept", 0, la(4, 0), lw(8'h11, 1'b1));
  endtask

  task automatic t_reserved();
    wr(0, la(1, 2), 32'hFFFF_FFFF, 2'd0);
    rd_chk("R8 reserved reads zero", 0, la(1, 2), 32'h0);
    rd_chk("R8 reserved write no lock", 1, la(1, 0), 32'h0);
    rd_chk("R8 reserved write no user", 1, la(1, 1), 32'h0);
    wr(0, la(7, 0), lw(8'h22, 1'b1), 2'd0);
    wr(0, la(7, 1), 32'hCAFE_F00D, 2'd0);
    rd_chk("R8 out of range lock", 0, la(7, 0), 32'h0);
    rd_chk("R8 out of range user", 0, la(7, 1), 32'h0);
    for (int k = 0; k < 4; k++)
      rd_chk("R8 no alias lock", 2, la(k, 0), 32'h0);
  endtask

  task automatic t_priority();
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      req_we[p] = 1'b0; req_addr[p] = la(4, 0); req_src[p] = '0;
    end
    req_valid = 3'b111;
    #1;
    chk("R9 grant port0", 32'(req_ready), 32'h1);
    @(negedge clk);
    chk("R9 done port0", 32'(resp_done), 32'h1);
    chk("R10 read data", resp_rdata, lw(8'h11, 1'b1));
    req_valid[0] = 1'b0;
    #1;
    chk("R9 grant port1", 32'(req_ready), 32'h2);
    @(negedge clk);
    chk("R9 done port1", 32'(resp_done), 32'h2);
    req_valid[1] = 1'b0;
    #1;
    chk("R9 grant port2", 32'(req_ready), 32'h4);
    @(negedge clk);
    chk("R9 done port2", 32'(resp_done), 32'h4);
    req_valid[2] = 1'b0;
    @(negedge clk);
    chk("R10 done single cycle", 32'(resp_done), 32'h0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset done low", 32'(resp_done), 32'h0);
    t_reset();
    t_claim();
    t_release();
    t_user();
    t_reserved();
    t_priority();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule